// File: doc/BRIEF.md
# External Bus Wait-State Inserter

This block sits between the access sequencer of a static memory bus controller and the external pins. It holds a short record of the access that last went out on the bus: its direction, the chip select it used, and the zero/non-zero state of the hold timings that applied to it. It compares that record with the access now pending. When the two accesses could collide on the pins, it raises a one-clock stall so the sequencer holds address, data and strobes for one extra cycle. It does not generate the setup, pulse or hold phases.

Three causes are kept apart and reported on a two-bit code. A change of chip select always wins. A read followed by a write on the same select costs a turnaround cycle when the read strobe had no hold. A write followed by a read on the same select costs an "early read" cycle under any of three timing conditions. Causes never add up: one gap is at most one cycle. The per-select timings arrive as flattened vectors, one field per chip select.

Top module: `ws_insert`

## Requirements
- R1: After reset the bus counts as idle, so the first accepted access is never stalled, whatever its chip select or direction.
- R2: A pending access whose chip select differs from the last accepted access is stalled for one cycle with wait code 2'b01.
- R3: A pending access with the same chip select and the same direction as the last accepted access is never stalled.
- R4: A read that follows a write on the same chip select gets wait code 2'b11 when the previous write strobe hold was zero and the read strobe setup of the pending read is zero.
- R5: A read that follows a write on the same chip select gets wait code 2'b11 when that select is in chip-select-controlled write mode (mode bit 0), its chip-select write hold is zero and its chip-select read setup is zero, whatever the read strobe setup is.
- R6: In write-strobe-controlled write mode (mode bit 1) with write strobe hold zero, a read that follows a write on the same select gets wait code 2'b11 when the write strobe feedback input is still 1 (active). With feedback 0 and no other condition met, no cycle is added.
- R7: A write that follows a read on the same chip select gets wait code 2'b10 when the read strobe hold of that select is zero.
- R8: Causes are never stacked. When the chip select changes, the code is 2'b01 and exactly one stall cycle is added, even if a same-select cause would also hold.
- R9: A stall lasts exactly one clock. The held request is accepted in the following cycle.
- R10: A write followed by a read on the same select, with non-zero strobe hold and setup and chip-select hold and setup, gets no wait cycle, and the feedback input has no effect in mode 0.
- R11: The wait code reads 2'b00 in every cycle in which stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is pending; held until accepted |
| req_write | input | 1 | Pending access is a write (1) or a read (0) |
| req_cs | input | CS_W | Chip select of the pending access |
| we_fb | input | 1 | Sampled write strobe feedback, 1 while still active |
| cfg_wr_mode | input | NUM_CS | Per select: 1 write-strobe-controlled, 0 chip-select-controlled |
| cfg_we_hold | input | NUM_CS*TW | Per select write strobe hold |
| cfg_cs_wr_hold | input | NUM_CS*TW | Per select chip-select hold after a write |
| cfg_rd_setup | input | NUM_CS*TW | Per select read strobe setup |
| cfg_cs_rd_setup | input | NUM_CS*TW | Per select chip-select setup before a read |
| cfg_rd_hold | input | NUM_CS*TW | Per select read strobe hold |
| stall | output | 1 | Insert one idle cycle now; hold the bus |
| wait_kind | output | 2 | 00 none, 01 select change, 10 read-to-write, 11 early read |

## Verification
The hardest case to reach is the early-read wait that depends only on the write strobe feedback. It needs a write on a select in strobe-controlled mode with zero strobe hold, then a read on that same select whose strobe setup and chip-select setup are both non-zero, so that no timing-only cause can fire. The stimulus sets up one chip select with exactly that mix of timings. It then runs the write-then-read pair once with feedback active and once with it inactive, and runs the same pair on a select in chip-select mode to show that the feedback has no effect there. A second reset in the middle of traffic checks that the record of the last access is cleared.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic [1:0] {
    WK_NONE = 2'b00,
    WK_CS   = 2'b01,
    WK_RW   = 2'b10,
    WK_ER   = 2'b11
  } wait_kind_e;
endpackage

// File: rtl/ws_cfg_pick.sv
// Selects one chip select's timing fields and reduces them to zero flags.
module ws_cfg_pick #(
  parameter int NUM_CS = 4,
  parameter int TW     = 3,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic [CS_W-1:0]      cs,
  input  logic [NUM_CS-1:0]    wr_mode,
  input  logic [NUM_CS*TW-1:0] we_hold,
  input  logic [NUM_CS*TW-1:0] cs_wr_hold,
  input  logic [NUM_CS*TW-1:0] rd_setup,
  input  logic [NUM_CS*TW-1:0] cs_rd_setup,
  input  logic [NUM_CS*TW-1:0] rd_hold,
  output logic                 mode_o,
  output logic                 we_hold_z,
  output logic                 cs_wr_hold_z,
  output logic                 rd_setup_z,
  output logic                 cs_rd_setup_z,
  output logic                 rd_hold_z
);
  logic [NUM_CS-1:0] we_hold_zv, cs_wr_hold_zv, rd_setup_zv, cs_rd_setup_zv, rd_hold_zv;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_zero
    assign we_hold_zv[g]     = (we_hold[g*TW +: TW] == '0);
    assign cs_wr_hold_zv[g]  = (cs_wr_hold[g*TW +: TW] == '0);
    assign rd_setup_zv[g]    = (rd_setup[g*TW +: TW] == '0);
    assign cs_rd_setup_zv[g] = (cs_rd_setup[g*TW +: TW] == '0);
    assign rd_hold_zv[g]     = (rd_hold[g*TW +: TW] == '0);
  end

  assign mode_o        = wr_mode[cs];
  assign we_hold_z     = we_hold_zv[cs];
  assign cs_wr_hold_z  = cs_wr_hold_zv[cs];
  assign rd_setup_z    = rd_setup_zv[cs];
  assign cs_rd_setup_z = cs_rd_setup_zv[cs];
  assign rd_hold_z     = rd_hold_zv[cs];
endmodule

// File: rtl/ws_history.sv
// Record of the last accepted access, loaded on acceptance.
module ws_history #(
  parameter int CS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            acc_write,
  input  logic [CS_W-1:0] acc_cs,
  input  logic            acc_mode,
  input  logic            acc_we_hold_z,
  input  logic            acc_cs_wr_hold_z,
  input  logic            acc_rd_hold_z,
  output logic            last_valid,
  output logic            last_write,
  output logic [CS_W-1:0] last_cs,
  output logic            last_mode,
  output logic            last_we_hold_z,
  output logic            last_cs_wr_hold_z,
  output logic            last_rd_hold_z
);
  logic            valid_d, write_d, mode_d, weh_d, csh_d, rdh_d;
  logic [CS_W-1:0] cs_d;

  always_comb begin
    valid_d = last_valid;
    write_d = last_write;
    cs_d    = last_cs;
    mode_d  = last_mode;
    weh_d   = last_we_hold_z;
    csh_d   = last_cs_wr_hold_z;
    rdh_d   = last_rd_hold_z;
    if (accept) begin
      valid_d = 1'b1;
      write_d = acc_write;
      cs_d    = acc_cs;
      mode_d  = acc_mode;
      weh_d   = acc_we_hold_z;
      csh_d   = acc_cs_wr_hold_z;
      rdh_d   = acc_rd_hold_z;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_valid        <= 1'b0;
      last_write        <= 1'b0;
      last_cs           <= '0;
      last_mode         <= 1'b0;
      last_we_hold_z    <= 1'b0;
      last_cs_wr_hold_z <= 1'b0;
      last_rd_hold_z    <= 1'b0;
    end else if (accept) begin
      last_valid        <= valid_d;
      last_write        <= write_d;
      last_cs           <= cs_d;
      last_mode         <= mode_d;
      last_we_hold_z    <= weh_d;
      last_cs_wr_hold_z <= csh_d;
      last_rd_hold_z    <= rdh_d;
    end
  end
endmodule

// File: rtl/ws_decide.sv
// Classifies the gap between the last and the pending access.
module ws_decide
  import ws_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic            last_valid,
  input  logic            last_write,
  input  logic [CS_W-1:0] last_cs,
  input  logic            last_mode,
  input  logic            last_we_hold_z,
  input  logic            last_cs_wr_hold_z,
  input  logic            last_rd_hold_z,
  input  logic            req_write,
  input  logic [CS_W-1:0] req_cs,
  input  logic            req_rd_setup_z,
  input  logic            req_cs_rd_setup_z,
  input  logic            we_fb,
  output wait_kind_e      kind
);
  logic same_cs, wr_to_rd, rd_to_wr, er_timing, er_cs_mode, er_fb;

  assign same_cs    = (last_cs == req_cs);
  assign wr_to_rd   = last_write && !req_write;
  assign rd_to_wr   = !last_write && req_write;
  assign er_timing  = last_we_hold_z && req_rd_setup_z;
  assign er_cs_mode = !last_mode && last_cs_wr_hold_z && req_cs_rd_setup_z;
  assign er_fb      = last_mode && last_we_hold_z && we_fb;

  always_comb begin
    kind = WK_NONE;
    if (last_valid) begin
      if (!same_cs)
        kind = WK_CS;
      else if (wr_to_rd && (er_timing || er_cs_mode || er_fb))
        kind = WK_ER;
      else if (rd_to_wr && last_rd_hold_z)
        kind = WK_RW;
    end
  end
endmodule

// File: rtl/ws_insert.sv
module ws_insert
  import ws_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int TW     = 3,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [CS_W-1:0]      req_cs,
  input  logic                 we_fb,
  input  logic [NUM_CS-1:0]    cfg_wr_mode,
  input  logic [NUM_CS*TW-1:0] cfg_we_hold,
  input  logic [NUM_CS*TW-1:0] cfg_cs_wr_hold,
  input  logic [NUM_CS*TW-1:0] cfg_rd_setup,
  input  logic [NUM_CS*TW-1:0] cfg_cs_rd_setup,
  input  logic [NUM_CS*TW-1:0] cfg_rd_hold,
  output logic                 stall,
  output logic [1:0]           wait_kind
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic            p_mode, p_weh_z, p_csh_z, p_rds_z, p_csrs_z, p_rdh_z;
  logic            h_valid, h_write, h_mode, h_weh_z, h_csh_z, h_rdh_z;
  logic [CS_W-1:0] h_cs;
  wait_kind_e      kind;
  logic            gap_done, gap_done_d, gap_en, accept;

  ws_cfg_pick #(.NUM_CS(NUM_CS), .TW(TW)) u_pick (
    .cs(req_cs), .wr_mode(cfg_wr_mode), .we_hold(cfg_we_hold),
    .cs_wr_hold(cfg_cs_wr_hold), .rd_setup(cfg_rd_setup),
    .cs_rd_setup(cfg_cs_rd_setup), .rd_hold(cfg_rd_hold),
    .mode_o(p_mode), .we_hold_z(p_weh_z), .cs_wr_hold_z(p_csh_z),
    .rd_setup_z(p_rds_z), .cs_rd_setup_z(p_csrs_z), .rd_hold_z(p_rdh_z)
  );

  ws_history #(.CS_W(CS_W)) u_hist (
    .clk(clk), .rst_n(rst_int_n), .accept(accept),
    .acc_write(req_write), .acc_cs(req_cs), .acc_mode(p_mode),
    .acc_we_hold_z(p_weh_z), .acc_cs_wr_hold_z(p_csh_z), .acc_rd_hold_z(p_rdh_z),
    .last_valid(h_valid), .last_write(h_write), .last_cs(h_cs),
    .last_mode(h_mode), .last_we_hold_z(h_weh_z),
    .last_cs_wr_hold_z(h_csh_z), .last_rd_hold_z(h_rdh_z)
  );

  ws_decide #(.CS_W(CS_W)) u_dec (
    .last_valid(h_valid), .last_write(h_write), .last_cs(h_cs),
    .last_mode(h_mode), .last_we_hold_z(h_weh_z),
    .last_cs_wr_hold_z(h_csh_z), .last_rd_hold_z(h_rdh_z),
    .req_write(req_write), .req_cs(req_cs),
    .req_rd_setup_z(p_rds_z), .req_cs_rd_setup_z(p_csrs_z),
    .we_fb(we_fb), .kind(kind)
  );

  assign stall     = req_valid && (kind != WK_NONE) && !gap_done;
  assign accept    = req_valid && !stall;
  assign wait_kind = stall ? kind : WK_NONE;

  // gap_done marks that the pending request already had its idle cycle
  assign gap_en = accept || stall;
  always_comb gap_done_d = stall;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  gap_done <= 1'b0;
    else if (gap_en) gap_done <= gap_done_d;
  end
endmodule

// File: rtl/ws_insert_chk.sv
module ws_insert_chk #(
  parameter int CS_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [CS_W-1:0] req_cs,
  input logic            stall,
  input logic [1:0]      wait_kind
);
  logic            seen, last_wr;
  logic [CS_W-1:0] last_cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      last_wr <= 1'b0;
      last_cs <= '0;
    end else if (req_valid && !stall) begin
      seen    <= 1'b1;
      last_wr <= req_write;
      last_cs <= req_cs;
    end
  end

  AST_FIRST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !seen) |-> !stall);                                        // R1
  AST_CS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seen && req_cs != last_cs && !$past(stall))
      |-> (stall && wait_kind == 2'b01));                                    // R2
  AST_SAME_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seen && req_cs == last_cs && req_write == last_wr) |-> !stall); // R3
  AST_ER_SAME_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_kind == 2'b11) |-> (req_cs == last_cs && !req_write && last_wr)); // R4
  AST_RW_SAME_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_kind == 2'b10) |-> (req_cs == last_cs && req_write && !last_wr)); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);                                                       // R9
  AST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (req_valid && $stable(req_cs) && $stable(req_write)));         // R9
  AST_KIND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> (wait_kind == 2'b00));                                        // R11
endmodule

bind ws_insert ws_insert_chk #(.CS_W(CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_cs(req_cs), .stall(stall), .wait_kind(wait_kind)
);

// File: tb/test_ws_insert.sv
module test_ws_insert;
  localparam int NUM_CS = 4;
  localparam int TW     = 3;
  localparam int CS_W   = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0, req_write = 1'b0, we_fb = 1'b0;
  logic [CS_W-1:0]      req_cs = '0;
  logic [NUM_CS-1:0]    cfg_wr_mode;
  logic [NUM_CS*TW-1:0] cfg_we_hold, cfg_cs_wr_hold, cfg_rd_setup, cfg_cs_rd_setup, cfg_rd_hold;
  logic                 stall;
  logic [1:0]           wait_kind;

  int n_run = 0, n_fail = 0, cycles = 0;

  typedef struct { logic [1:0] kind; string tag; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  ws_insert #(.NUM_CS(NUM_CS), .TW(TW)) i_ws_insert (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cs(req_cs), .we_fb(we_fb), .cfg_wr_mode(cfg_wr_mode),
    .cfg_we_hold(cfg_we_hold), .cfg_cs_wr_hold(cfg_cs_wr_hold),
    .cfg_rd_setup(cfg_rd_setup), .cfg_cs_rd_setup(cfg_cs_rd_setup),
    .cfg_rd_hold(cfg_rd_hold), .stall(stall), .wait_kind(wait_kind)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: accumulates stall cycles of the current access, compares on accept
  int         stalls_seen = 0;
  logic [1:0] kind_seen = 2'b00;
  always @(negedge clk) begin
    cycles++;
    if (rst_n && req_valid) begin
      if (stall) begin
        stalls_seen++;
        kind_seen = wait_kind;
      end else begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check(1'b0, "scoreboard empty", 0, 1);
        end else begin
          e = exp_q.pop_front();
          check(kind_seen == e.kind, e.tag, kind_seen, e.kind);
          check(stalls_seen == (e.kind != 2'b00 ? 1 : 0), {e.tag, " R9 stall count"},
                stalls_seen, (e.kind != 2'b00 ? 1 : 0));
        end
        stalls_seen = 0;
        kind_seen   = 2'b00;
      end
    end else if (rst_n && !req_valid) begin
      check(!stall && wait_kind == 2'b00, "R11 idle outputs", {stall, wait_kind}, 0);
    end
  end

  // driver: pushes the expected code, holds the request until accepted
  task automatic access(input int cs, input bit wr, input bit fb, input logic [1:0] k,
                        input string tag);
    bit acc;
    exp_t e;
    e.kind = k; e.tag = tag;
    exp_q.push_back(e);
    req_valid = 1'b1; req_cs = CS_W'(cs); req_write = wr; we_fb = fb;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk); acc = !stall;
      @(posedge clk); #1;
    end
    req_valid = 1'b0; we_fb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic set_cs(input int cs, input bit mode, input int weh, input int csh,
                        input int rds, input int csrs, input int rdh);
    cfg_wr_mode[cs]           = mode;
    cfg_we_hold[cs*TW +: TW]     = TW'(weh);
    cfg_cs_wr_hold[cs*TW +: TW]  = TW'(csh);
    cfg_rd_setup[cs*TW +: TW]    = TW'(rds);
    cfg_cs_rd_setup[cs*TW +: TW] = TW'(csrs);
    cfg_rd_hold[cs*TW +: TW]     = TW'(rdh);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 5000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    //        cs mode weh csh rds csrs rdh
    set_cs(0, 1'b1, 0, 1, 0, 1, 1);  // strobe timing early read
    set_cs(1, 1'b0, 1, 0, 2, 0, 0);  // chip-select mode early read, turnaround
    set_cs(2, 1'b1, 0, 1, 1, 1, 2);  // feedback-only early read
    set_cs(3, 1'b0, 1, 1, 1, 1, 1);  // never waits on same select
    idle(3);
    rst_n = 1'b1;
    idle(3);
    @(negedge clk);
    check(stall == 1'b0 && wait_kind == 2'b00, "R1 reset state", {stall, wait_kind}, 0);
    @(posedge clk); #1;

    access(0, 0, 0, 2'b00, "R1 first access");
    access(0, 0, 0, 2'b00, "R3 read-read");
    access(0, 1, 0, 2'b00, "R7 read hold nonzero");
    access(0, 1, 0, 2'b00, "R3 write-write");
    access(0, 0, 0, 2'b11, "R4 strobe timing");
    access(2, 1, 0, 2'b01, "R2 select change");
    idle(2);
    access(2, 0, 1, 2'b11, "R6 feedback active");
    access(2, 1, 0, 2'b00, "R7 read hold nonzero cs2");
    access(2, 0, 0, 2'b00, "R6 feedback inactive");
    access(1, 0, 0, 2'b01, "R2 select change cs1");
    access(1, 1, 0, 2'b10, "R7 read-to-write");
    access(1, 0, 0, 2'b11, "R5 chip-select mode");
    access(1, 1, 0, 2'b10, "R7 read-to-write again");
    access(0, 0, 1, 2'b01, "R8 select change wins");
    access(3, 1, 0, 2'b01, "R8 single cycle");
    access(3, 0, 1, 2'b00, "R10 no wait, feedback ignored");
    access(3, 0, 0, 2'b00, "R10 read-read");

    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
    access(1, 1, 0, 2'b00, "R1 after second reset");
    access(2, 0, 0, 2'b01, "R2 after second reset");
    idle(3);

    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule